// File: doc/BRIEF.md
# ATA Task-File Register Block

This block is the device side of an ATA register set for a single drive. A host reaches it through a synchronous strobe interface. That interface has a 3-bit register offset, a byte-wide write bus and a 16-bit read bus. Offset 0 is the 16-bit data port. The other seven offsets hold the sector-count, LBA and device registers. They also provide error readback on one offset and command-write/status-read on another. Read data is registered and appears on `host_rdata` in the cycle after the read strobe.

Two command flows are supported:

- **Identify.** The identify opcode 0xEC starts a PIO-in block of 256 words. The words are computed by a small internal ROM.
- **Flush.** The flush opcode 0xE7 holds the drive busy until an external completion strobe arrives.

Any other opcode is aborted with an error. Events raise an interrupt line, and a host read of the status register drops it.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x40 (ready only), error reads 0x00, `irq` is low, and the sector-count, LBA and device registers read 0x00.
- R2: A write to offset 2, 3, 4, 5 or 6 stores `host_wdata` and a later read of that offset returns it in `host_rdata[7:0]`, with the upper byte zero. Read data is valid in the cycle after `host_rd`.
- R3: Writing 0xEC to offset 7 raises `irq`. Every status read during the following 256 data-port reads returns 0x48 (ready and data-request set; busy, fault and error clear).
- R4: Data word k (0..255) of the identify block has low byte k and high byte ~k. The low byte is on `host_rdata[7:0]`. After the 256th data read, status reads 0x40.
- R5: A data-port read while no data request is pending returns 0x0000 and leaves the status unchanged.
- R6: A status read (offset 7) drops a pending `irq` in the same cycle it is sampled. An error-register read (offset 1) leaves `irq` unchanged.
- R7: Writing 0xE7 makes status read 0xC0 (busy and ready) until `op_done` is pulsed. After that pulse, status reads 0x40 and `irq` rises in the same edge as busy falls.
- R8: Any opcode other than 0xEC and 0xE7 sets status to 0x41 and error to 0x04 (aborted), and raises `irq`. The next accepted command clears the error.
- R9: While busy (status bit 0x80) is set, writes to every offset, including the command offset, are ignored.
- R10: While device register bit 0x10 (second drive) is set, status reads return 0x00, do not drop `irq`, and command writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Registered read data |
| op_done | input | 1 | Completion pulse for the flush command |
| irq | output | 1 | Interrupt request to the host |

## Verification
The register path is exercised with a table of distinct byte values across all five writable offsets. Each value has a different bit pattern, so a swapped offset or a dropped bit shows up. The identify block is read out in full and every word is compared against the index-derived pattern. This separates an off-by-one in the word counter from a byte-order swap, because the high byte is the complement of the low byte. The flush, abort and second-drive flows are driven as directed sequences. Writes are issued while busy, and reads are issued of the error register, so that side-effect-free accesses can be told apart from those that change state.

// File: rtl/ata_tf_pkg.sv
// Shared constants and types for the ATA task-file block.
// Assumes byte-wide register offsets 0..7 and a single present drive.
package ata_tf_pkg;
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_ERR   = 3'd1;
    localparam logic [2:0] OFS_NSECT = 3'd2;
    localparam logic [2:0] OFS_LBA0  = 3'd3;
    localparam logic [2:0] OFS_LBA1  = 3'd4;
    localparam logic [2:0] OFS_LBA2  = 3'd5;
    localparam logic [2:0] OFS_DEV   = 3'd6;
    localparam logic [2:0] OFS_CMD   = 3'd7;

    localparam logic [7:0] OP_IDENT  = 8'hEC;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;

    localparam logic [7:0] ERR_ABORT = 8'h04;
    localparam int         DEV_SEL_BIT = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PIO  = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ata_id_rom.sv
// Identify data source: word k carries k in its low byte and ~k in its high byte.
// Assumes an 8-bit word index, so at most 256 words.
module ata_id_rom (
    input  logic [7:0]  idx,
    output logic [15:0] word
);
    // Compute the word for the requested index.
    always_comb begin
        word = {~idx, idx};
    end
endmodule

// File: rtl/ata_cmd_seq.sv
// Command sequencer: accepts opcodes, runs the PIO-in word count and the
// busy wait of the flush command, and flags aborted opcodes.
// Assumes cmd_stb only arrives while not busy (the parent gates it).
module ata_cmd_seq
    import ata_tf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic [7:0]       cmd_code,
    input  logic             data_rd_stb,
    input  logic             done_stb,
    output logic             bsy,
    output logic             drq,
    output logic             err,
    output logic [IDX_W-1:0] word_idx,
    output logic             irq_set
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_t state;

    // State, word counter and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            word_idx <= '0;
            err      <= 1'b0;
        end else if (cmd_stb) begin
            word_idx <= '0;
            err      <= 1'b0;
            case (cmd_code)
                OP_IDENT: state <= SEQ_PIO;
                OP_FLUSH: state <= SEQ_BUSY;
                default: begin
                    state <= SEQ_IDLE;
                    err   <= 1'b1;
                end
            endcase
        end else if (state == SEQ_PIO && data_rd_stb) begin
            if (word_idx == LAST_IDX) begin
                state    <= SEQ_IDLE;
                word_idx <= '0;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end else if (state == SEQ_BUSY && done_stb) begin
            state <= SEQ_IDLE;
        end
    end

    // Status flags decoded from the state.
    always_comb begin
        bsy = (state == SEQ_BUSY);
        drq = (state == SEQ_PIO);
    end

    // Interrupt event: every command acceptance except flush, and flush completion.
    always_comb begin
        irq_set = (cmd_stb && cmd_code != OP_FLUSH) ||
                  (state == SEQ_BUSY && done_stb);
    end
endmodule

// File: rtl/ata_taskfile.sv
// ATA task-file register block, device side, single drive.
// Holds the addressing registers, builds status/error readback, drives the
// interrupt line and hands commands to the sequencer. Assumes host_rd and
// host_wr are never asserted in the same cycle.
module ata_taskfile
    import ata_tf_pkg::*;
#(
    parameter int WORDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  host_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [15:0] host_rdata,
    input  logic        op_done,
    output logic        irq
);
    localparam int IDX_W = $clog2(WORDS);

    logic [7:0] nsect_q, lba0_q, lba1_q, lba2_q, dev_q;
    logic [7:0] status, err_byte;
    logic [IDX_W-1:0] word_idx;
    logic [15:0] rom_word;
    logic bsy, drq, err, irq_set;
    logic dev1, wr_ok, cmd_stb, data_rd_stb, status_rd;

    // Access qualifiers.
    always_comb begin
        dev1        = dev_q[DEV_SEL_BIT];
        wr_ok       = host_wr && !bsy;
        cmd_stb     = wr_ok && host_addr == OFS_CMD && !dev1;
        data_rd_stb = host_rd && host_addr == OFS_DATA && drq;
        status_rd   = host_rd && host_addr == OFS_CMD && !dev1;
    end

    // Status and error bytes; a deselected drive reads all zero.
    always_comb begin
        status   = dev1 ? 8'h00 : {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};
        err_byte = err ? ERR_ABORT : 8'h00;
    end

    // Addressing register file, written only when not busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsect_q <= '0;
            lba0_q  <= '0;
            lba1_q  <= '0;
            lba2_q  <= '0;
            dev_q   <= '0;
        end else if (wr_ok) begin
            case (host_addr)
                OFS_NSECT: nsect_q <= host_wdata;
                OFS_LBA0:  lba0_q  <= host_wdata;
                OFS_LBA1:  lba1_q  <= host_wdata;
                OFS_LBA2:  lba2_q  <= host_wdata;
                OFS_DEV:   dev_q   <= host_wdata;
                default: ;
            endcase
        end
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            case (host_addr)
                OFS_DATA:  host_rdata <= drq ? rom_word : 16'h0000;
                OFS_ERR:   host_rdata <= {8'h00, err_byte};
                OFS_NSECT: host_rdata <= {8'h00, nsect_q};
                OFS_LBA0:  host_rdata <= {8'h00, lba0_q};
                OFS_LBA1:  host_rdata <= {8'h00, lba1_q};
                OFS_LBA2:  host_rdata <= {8'h00, lba2_q};
                OFS_DEV:   host_rdata <= {8'h00, dev_q};
                default:   host_rdata <= {8'h00, status};
            endcase
        end
    end

    // Interrupt line: a new event wins over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (irq_set)   irq <= 1'b1;
        else if (status_rd) irq <= 1'b0;
    end

    ata_cmd_seq #(.WORDS(WORDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_stb     (cmd_stb),
        .cmd_code    (host_wdata),
        .data_rd_stb (data_rd_stb),
        .done_stb    (op_done),
        .bsy         (bsy),
        .drq         (drq),
        .err         (err),
        .word_idx    (word_idx),
        .irq_set     (irq_set)
    );

    ata_id_rom u_rom (
        .idx  (8'(word_idx)),
        .word (rom_word)
    );
endmodule

// File: rtl/ata_taskfile_chk.sv
// Property checker for ata_taskfile, attached by bind below.
// Assumes the same parameter value as the bound instance.
module ata_taskfile_chk #(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       host_addr,
    input logic             host_wr,
    input logic             host_rd,
    input logic             op_done,
    input logic             irq,
    input logic             bsy,
    input logic             drq,
    input logic             dev1,
    input logic [7:0]       lba0_q,
    input logic [IDX_W-1:0] word_idx
);
    // R3
    drq_bsy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));

    // R4
    last_word_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && host_rd && !host_wr && host_addr == 3'd0 &&
         word_idx == IDX_W'(WORDS - 1)) |=> !drq);

    // R6
    status_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_addr == 3'd7 && !dev1 && !op_done) |=> !irq);

    // R7
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && !op_done) |=> bsy);

    // R7
    busy_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bsy) |-> irq);

    // R9
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && host_wr && host_addr == 3'd3) |=> $stable(lba0_q));
endmodule

bind ata_taskfile ata_taskfile_chk #(.WORDS(WORDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .op_done   (op_done),
    .irq       (irq),
    .bsy       (bsy),
    .drq       (drq),
    .dev1      (dev1),
    .lba0_q    (lba0_q),
    .word_idx  (word_idx)
);

// File: tb/ata_taskfile_bench.sv
// Self-checking bench for ata_taskfile: table-driven register checks, then
// directed identify, flush, abort, busy-write and second-drive sequences.
module ata_taskfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [15:0] host_rdata;
    logic        op_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Register table: {offset, value}.
    localparam logic [15:0] VEC [5] = '{16'h0212, 16'h0334, 16'h0456, 16'h059A, 16'h06E0};

    ata_taskfile u_ata_taskfile (.*);

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Compare one value and log a failure.
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write at the falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // One-cycle read; data sampled at the next falling edge.
    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    // Pulse the completion strobe for one cycle.
    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // Print the summary line and stop.
    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    // Main stimulus.
    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        rd(3'd7, v); chk("R1 status", v, 16'h0040);
        rd(3'd1, v); chk("R1 error", v, 16'h0000);
        for (int i = 2; i <= 6; i++) begin
            rd(3'(i), v); chk("R1 reg", v, 16'h0000);
        end

        // R2 table walk
        for (int i = 0; i < 5; i++) wr(VEC[i][10:8], VEC[i][7:0]);
        for (int i = 0; i < 5; i++) begin
            rd(VEC[i][10:8], v); chk("R2 readback", v, {8'h00, VEC[i][7:0]});
        end

        // R5 data read with no request pending
        rd(3'd0, v); chk("R5 data idle", v, 16'h0000);
        rd(3'd7, v); chk("R5 status", v, 16'h0040);

        // R3 / R4 identify
        wr(3'd7, 8'hEC);
        chk("R3 irq raised", {15'd0, irq}, 16'h0001);
        for (int k = 0; k < 256; k++) begin
            rd(3'd7, v); chk("R3 status in block", v, 16'h0048);
            if (k == 0) chk("R6 irq cleared", {15'd0, irq}, 16'h0000);
            rd(3'd0, v); chk("R4 word", v, {~8'(k), 8'(k)});
        end
        rd(3'd7, v); chk("R4 status after block", v, 16'h0040);

        // R8 unknown opcode and R6 error read keeps irq
        wr(3'd7, 8'h5A);
        chk("R8 irq", {15'd0, irq}, 16'h0001);
        rd(3'd1, v); chk("R8 error", v, 16'h0004);
        chk("R6 error read keeps irq", {15'd0, irq}, 16'h0001);
        rd(3'd7, v); chk("R8 status", v, 16'h0041);
        chk("R6 status read clears", {15'd0, irq}, 16'h0000);

        // R7 flush, R9 writes while busy
        wr(3'd7, 8'hE7);
        chk("R7 no irq at start", {15'd0, irq}, 16'h0000);
        rd(3'd7, v); chk("R7 busy status", v, 16'h00C0);
        rd(3'd1, v); chk("R8 error cleared", v, 16'h0000);
        wr(3'd3, 8'h77);
        wr(3'd7, 8'hEC);
        rd(3'd7, v); chk("R9 cmd ignored", v, 16'h00C0);
        pulse_done();
        chk("R7 irq on done", {15'd0, irq}, 16'h0001);
        rd(3'd7, v); chk("R7 status after done", v, 16'h0040);
        rd(3'd3, v); chk("R9 lba kept", v, 16'h0034);

        // R10 second drive selected
        wr(3'd7, 8'h5A);
        wr(3'd6, 8'h50);
        rd(3'd7, v); chk("R10 status zero", v, 16'h0000);
        chk("R10 irq kept", {15'd0, irq}, 16'h0001);
        wr(3'd7, 8'hE7);
        wr(3'd6, 8'h40);
        rd(3'd7, v); chk("R10 cmd ignored", v, 16'h0041);

        finished = 1'b1;
        finish_run();
    end
endmodule